// File: doc/BRIEF.md
# Wide 36x36 Multiplier Built from Half-Width Products

This block multiplies two 36-bit operands into a 72-bit product. Each operand is cut into an upper and a lower 18-bit half. Four 18x18 sub-multipliers form the products of every pairing of halves. A summation stage weights those four products and adds them. A separate control input for each operand marks it as two's complement or unsigned, so signed, unsigned and mixed multiplies all run on the same hardware.

A build parameter can place a register between the sub-multipliers and the adder. This trades one cycle of latency for a shorter path to the output register. A valid bit travels through the pipeline beside the data. One clock enable stalls every stage at once. The sign controls are sampled on the same edge as the operands, so they may change from one operation to the next.

Top module: `wide_mult36`

## Requirements
- R1: For each accepted operation, `product` equals the full product of `opA` and `opB`, each read according to its own sign control, in 72-bit two's complement. The lower 18 bits of each operand always count as an unsigned magnitude.
- R2: When `aSigned` is 1, `opA` is read as two's complement, and when it is 0, as unsigned. `bSigned` does the same for `opB`. All four combinations give exact results.
- R3: Latency counts enabled clock edges. With `MID_REG`=1 the result appears after 2 such edges. With `MID_REG`=0 it appears after 1.
- R4: `outValid` is 1 for exactly one enabled cycle for each operation accepted with `inValid`=1 and `clkEn`=1, and results leave in the order they were accepted.
- R5: A clock edge with `clkEn`=0 changes nothing. `outValid` and `product` keep their values, and the inputs present at that edge are discarded.
- R6: While `outValid` is 0, `product` keeps the last result that was presented with `outValid`=1.
- R7: While `rstN` is 0, a clock edge clears `outValid` and `product` to 0.
- R8: The sign controls travel with their own operands. Back-to-back operations with different sign settings each use the setting sampled with their own operands.
- R9: Extreme operands give exact results. Examples: -2^35 x -2^35 = 2^70, and (2^36-1)^2 unsigned. Whenever at least one operand is signed and neither is zero, bit 71 equals the sign of the true product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| clkEn | input | 1 | Clock enable for every stage |
| inValid | input | 1 | Operands valid this cycle |
| opA | input | 36 | First operand |
| opB | input | 36 | Second operand |
| aSigned | input | 1 | 1: opA is two's complement |
| bSigned | input | 1 | 1: opB is two's complement |
| outValid | output | 1 | Product valid |
| product | output | 72 | 72-bit result |

## Verification
Some properties are checked on every cycle:
- A stalled edge leaves `outValid` and `product` untouched.
- `outValid` only rises on an enabled edge.
- A result whose operands included a zero is zero.
- When a signed operand is involved, the sign bit of the result matches the sign predicted from the operand MSBs, which are carried alongside the data.

The exact arithmetic cannot be shown by those properties. Neither can the weighting of the four sub-products, the unsigned handling of the lower halves, or the latency of each variant. Only the bench scenarios show these, by comparing both pipeline variants against an independent 72-bit multiply over random, extreme and sign-toggling inputs.

// File: rtl/mul36_pkg.sv
`timescale 1ns/1ps
package mul36_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadMid;   // capture sub-products into the middle stage
    logic loadOut;   // capture the weighted sum into the output stage
  } stageStrobe_t;

  localparam int NUM_PP = 4;

endpackage

// File: rtl/sub_mult.sv
`timescale 1ns/1ps
module sub_mult #(
  parameter int HALF_W = 18
) (
  input  logic [HALF_W-1:0]     x,
  input  logic [HALF_W-1:0]     y,
  input  logic                  xSigned,
  input  logic                  ySigned,
  output logic [2*HALF_W+1:0]   prod
);

  // one extra bit per side lets unsigned halves sit in a signed multiply
  logic signed [HALF_W:0]     xExt;
  logic signed [HALF_W:0]     yExt;
  logic signed [2*HALF_W+1:0] prodS;

  assign xExt  = {xSigned & x[HALF_W-1], x};
  assign yExt  = {ySigned & y[HALF_W-1], y};
  assign prodS = xExt * yExt;
  assign prod  = prodS;

endmodule

// File: rtl/mult_ctrl.sv
`timescale 1ns/1ps
module mult_ctrl
  import mul36_pkg::*;
#(
  parameter bit MID_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clkEn,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);

  generate
    if (MID_REG) begin : g_twoStage
      logic midValid;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          midValid <= 1'b0;
          outValid <= 1'b0;
        end else if (clkEn) begin
          midValid <= inValid;
          outValid <= midValid;
        end
      end

      always_comb begin
        strobe.loadMid = clkEn & inValid;
        strobe.loadOut = clkEn & midValid;
      end
    end else begin : g_oneStage
      always_ff @(posedge clk) begin
        if (!rstN) begin
          outValid <= 1'b0;
        end else if (clkEn) begin
          outValid <= inValid;
        end
      end

      always_comb begin
        strobe.loadMid = 1'b0;
        strobe.loadOut = clkEn & inValid;
      end
    end
  endgenerate

  AST_VALID_RISES_ON_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(clkEn)); // R4

  AST_STALL_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clkEn) |-> $stable(outValid)); // R5

endmodule

// File: rtl/mult_datapath.sv
`timescale 1ns/1ps
module mult_datapath
  import mul36_pkg::*;
#(
  parameter int HALF_W  = 18,
  parameter bit MID_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  stageStrobe_t        strobe,
  input  logic [2*HALF_W-1:0] opA,
  input  logic [2*HALF_W-1:0] opB,
  input  logic                aSigned,
  input  logic                bSigned,
  output logic [4*HALF_W-1:0] product
);

  localparam int OP_W  = 2 * HALF_W;
  localparam int RES_W = 2 * OP_W;
  localparam int PP_W  = 2 * HALF_W + 2;

  logic [NUM_PP-1:0][PP_W-1:0]  ppNow;
  logic [NUM_PP-1:0][PP_W-1:0]  ppUse;
  logic [NUM_PP-1:0][RES_W-1:0] term;
  logic [RES_W-1:0]             sum;

  // sideband describing the expected result, carried for the checks
  logic negNow, nzNow, anySgnNow;
  logic negUse, nzUse, anySgnUse;
  logic outNeg, outNz, outAnySgn;

  assign negNow    = (aSigned & opA[OP_W-1]) ^ (bSigned & opB[OP_W-1]);
  assign nzNow     = (|opA) & (|opB);
  assign anySgnNow = aSigned | bSigned;

  // k[1] picks the half of A, k[0] the half of B
  generate
    for (genvar k = 0; k < NUM_PP; k++) begin : g_pp
      localparam int A_HI  = k / 2;
      localparam int B_HI  = k % 2;
      localparam int SHIFT = (A_HI + B_HI) * HALF_W;

      logic [HALF_W-1:0] xHalf;
      logic [HALF_W-1:0] yHalf;
      logic              xSgn;
      logic              ySgn;

      if (A_HI == 1) begin : g_aHi
        assign xHalf = opA[OP_W-1:HALF_W];
        assign xSgn  = aSigned;
      end else begin : g_aLo
        assign xHalf = opA[HALF_W-1:0];
        assign xSgn  = 1'b0;
      end

      if (B_HI == 1) begin : g_bHi
        assign yHalf = opB[OP_W-1:HALF_W];
        assign ySgn  = bSigned;
      end else begin : g_bLo
        assign yHalf = opB[HALF_W-1:0];
        assign ySgn  = 1'b0;
      end

      sub_mult #(.HALF_W(HALF_W)) u_sub (
        .x       (xHalf),
        .y       (yHalf),
        .xSigned (xSgn),
        .ySigned (ySgn),
        .prod    (ppNow[k])
      );

      assign term[k] = RES_W'($signed(ppUse[k])) << SHIFT;
    end
  endgenerate

  generate
    if (MID_REG) begin : g_midReg
      logic [NUM_PP-1:0][PP_W-1:0] ppMid;
      logic negMid, nzMid, anySgnMid;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          ppMid     <= '0;
          negMid    <= 1'b0;
          nzMid     <= 1'b0;
          anySgnMid <= 1'b0;
        end else if (strobe.loadMid) begin
          ppMid     <= ppNow;
          negMid    <= negNow;
          nzMid     <= nzNow;
          anySgnMid <= anySgnNow;
        end
      end

      assign ppUse     = ppMid;
      assign negUse    = negMid;
      assign nzUse     = nzMid;
      assign anySgnUse = anySgnMid;
    end else begin : g_noMid
      logic unusedMid;
      assign unusedMid = strobe.loadMid;
      assign ppUse     = ppNow;
      assign negUse    = negNow;
      assign nzUse     = nzNow;
      assign anySgnUse = anySgnNow;
    end
  endgenerate

  always_comb begin
    sum = '0;
    for (int k = 0; k < NUM_PP; k++) begin
      sum = sum + term[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      product   <= '0;
      outNeg    <= 1'b0;
      outNz     <= 1'b0;
      outAnySgn <= 1'b0;
    end else if (strobe.loadOut) begin
      product   <= sum;
      outNeg    <= negUse;
      outNz     <= nzUse;
      outAnySgn <= anySgnUse;
    end
  end

  AST_PRODUCT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.loadOut) |-> $stable(product)); // R6

  AST_RESULT_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (outNz && outAnySgn) |-> (product[RES_W-1] == outNeg)); // R9

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rstN)
    !outNz |-> (product == '0)); // R1

endmodule

// File: rtl/wide_mult36.sv
`timescale 1ns/1ps
module wide_mult36
  import mul36_pkg::*;
#(
  parameter int HALF_W  = 18,
  parameter bit MID_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clkEn,
  input  logic                inValid,
  input  logic [2*HALF_W-1:0] opA,
  input  logic [2*HALF_W-1:0] opB,
  input  logic                aSigned,
  input  logic                bSigned,
  output logic                outValid,
  output logic [4*HALF_W-1:0] product
);

  stageStrobe_t strobe;

  mult_ctrl #(.MID_REG(MID_REG)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  mult_datapath #(.HALF_W(HALF_W), .MID_REG(MID_REG)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .aSigned (aSigned),
    .bSigned (bSigned),
    .product (product)
  );

endmodule

// File: tb/test_wide_mult36.sv
`timescale 1ns/1ps
module test_wide_mult36;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b0;
  logic        inValid = 1'b0;
  logic [35:0] opA = '0;
  logic [35:0] opB = '0;
  logic        aSigned = 1'b0;
  logic        bSigned = 1'b0;
  logic        ov0, ov1;
  logic [71:0] pr0, pr1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic lastEn = 1'b0;

  logic [71:0] q0[$];
  logic [71:0] q1[$];
  string       t0[$];
  string       t1[$];
  logic        prevOv[2];
  logic [71:0] prevPr[2];
  logic [71:0] lastGood[2];

  always #2.5 clk = ~clk;

  wide_mult36 i_wide_mult36 (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .inValid(inValid),
    .opA(opA), .opB(opB), .aSigned(aSigned), .bSigned(bSigned),
    .outValid(ov1), .product(pr1)
  );

  wide_mult36 #(.MID_REG(1'b0)) i_wide_mult36_flat (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .inValid(inValid),
    .opA(opA), .opB(opB), .aSigned(aSigned), .bSigned(bSigned),
    .outValid(ov0), .product(pr0)
  );

  function automatic logic [71:0] refMul(input logic [35:0] a, input logic [35:0] b,
                                          input logic sa, input logic sb);
    logic signed [72:0] ea, eb, p;
    ea = sa ? {{37{a[35]}}, a} : {37'b0, a};
    eb = sb ? {{37{b[35]}}, b} : {37'b0, b};
    p  = ea * eb;
    return p[71:0];
  endfunction

  task automatic chk(input string req, input string who, input bit ok,
                     input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, who, act, exp);
    end
  endtask

  task automatic scoreboard(input int idx, input logic ov, input logic [71:0] pr);
    string who;
    logic [71:0] e;
    string tag;
    who = (idx == 0) ? "flat" : "piped";
    if (!lastEn) begin
      // R5: a stalled edge changes neither output
      chk("R5", who, ov == prevOv[idx] && pr == prevPr[idx], {ov, pr}, {prevOv[idx], prevPr[idx]});
    end else if (ov) begin
      if ((idx == 0 && q0.size() == 0) || (idx == 1 && q1.size() == 0)) begin
        chk("R4", who, 1'b0, {71'b0, ov}, 72'd0);
      end else begin
        if (idx == 0) begin e = q0.pop_front(); tag = t0.pop_front(); end
        else          begin e = q1.pop_front(); tag = t1.pop_front(); end
        chk(tag, who, pr == e, pr, e);
      end
      lastGood[idx] = pr;
    end else begin
      // R6: without a valid result the product stays at the last one
      chk("R6", who, pr == lastGood[idx], pr, lastGood[idx]);
    end
    prevOv[idx] = ov;
    prevPr[idx] = pr;
  endtask

  task automatic step(input logic v, input logic en, input logic [35:0] a, input logic [35:0] b,
                      input logic sa, input logic sb, input string tag);
    logic [71:0] e;
    inValid = v; clkEn = en; opA = a; opB = b; aSigned = sa; bSigned = sb;
    if (v && en) begin
      e = refMul(a, b, sa, sb);
      q0.push_back(e); q1.push_back(e);
      t0.push_back(tag); t1.push_back(tag);
    end
    lastEn = en;
    @(posedge clk);
    @(negedge clk);
    scoreboard(0, ov0, pr0);
    scoreboard(1, ov1, pr1);
  endtask

  function automatic logic [35:0] pickOp(input int sel);
    case (sel)
      0: return 36'h0;
      1: return 36'hF_FFFF_FFFF;
      2: return 36'h8_0000_0000;
      3: return 36'h7_FFFF_FFFF;
      4: return 36'h1;
      5: return 36'h0_0002_0000;
      default: return {$urandom(), $urandom()} & 36'hF_FFFF_FFFF;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [35:0] ext[4];
    void'($urandom(32'd4242));
    for (int i = 0; i < 2; i++) begin
      prevOv[i] = 1'b0; prevPr[i] = '0; lastGood[i] = '0;
    end
    opA = 36'hA_5A5A_5A5A; opB = 36'h3_3333_3333; inValid = 1'b1; clkEn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset clears both outputs
    chk("R7", "piped", ov1 == 1'b0 && pr1 == '0, {ov1, pr1}, 72'd0);
    chk("R7", "flat",  ov0 == 1'b0 && pr0 == '0, {ov0, pr0}, 72'd0);
    rstN = 1'b1;

    // R3: latency of each variant from an idle pipeline
    repeat (3) step(1'b0, 1'b1, '0, '0, 1'b0, 1'b0, "R6");
    step(1'b1, 1'b1, 36'd123456, 36'd654321, 1'b0, 1'b0, "R3");
    chk("R3", "flat",  ov0 == 1'b1, {71'b0, ov0}, 72'd1);
    chk("R3", "piped", ov1 == 1'b0, {71'b0, ov1}, 72'd0);
    step(1'b0, 1'b1, '0, '0, 1'b0, 1'b0, "R6");
    chk("R3", "piped", ov1 == 1'b1, {71'b0, ov1}, 72'd1);
    chk("R3", "flat",  ov0 == 1'b0, {71'b0, ov0}, 72'd0);

    // R9 / R2: extreme values under every sign combination
    ext[0] = 36'h8_0000_0000; ext[1] = 36'hF_FFFF_FFFF;
    ext[2] = 36'h7_FFFF_FFFF; ext[3] = 36'h0_0003_FFFF;
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          step(1'b1, 1'b1, ext[i], ext[j], s[1], s[0], "R9");
        end
      end
    end

    // R8: same operands, sign controls toggling every cycle
    for (int s = 0; s < 8; s++) begin
      step(1'b1, 1'b1, 36'hC_0001_2345, 36'h9_8765_4321, s[0], s[1], "R8");
    end

    // R5: operands offered during a stall are discarded
    step(1'b1, 1'b0, 36'h1_2345_6789, 36'h2, 1'b1, 1'b1, "R5");
    step(1'b1, 1'b0, 36'hF_0000_0000, 36'h3, 1'b0, 1'b1, "R5");
    step(1'b0, 1'b1, '0, '0, 1'b0, 1'b0, "R6");

    // R1 / R2: random traffic with stalls and gaps
    for (int n = 0; n < 600; n++) begin
      logic v, en;
      v  = ($urandom() % 4) != 0;
      en = ($urandom() % 5) != 0;
      step(v, en, pickOp($urandom() % 10), pickOp($urandom() % 10),
           $urandom() % 2, $urandom() % 2, "R1");
    end

    repeat (4) step(1'b0, 1'b1, '0, '0, 1'b0, 1'b0, "R6");
    // R4: every accepted operation produced exactly one result
    chk("R4", "flat",  q0.size() == 0, 72'(q0.size()), 72'd0);
    chk("R4", "piped", q1.size() == 0, 72'(q1.size()), 72'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule